// File: doc/BRIEF.md
# Interrupt Enable and Mode Controller

This block holds the maskable-interrupt state of a CPU core: a live enable flag, a saved enable flag, the acknowledge mode and a suspended (halted) state. The instruction decoder reports instruction completion with an `insn_end` pulse. One-hot strobes on that same cycle name the instruction that just finished: enable, disable, mode select, halt, sleep, return-from-NMI or return-from-interrupt. Strobes on cycles without `insn_end` have no effect. An interrupt can only be taken at an instruction boundary, meaning an `insn_end` cycle or any cycle while suspended.

When a request is taken, the block sends a one-cycle `take_o` pulse in the cycle after the boundary, together with a vector description. The description is either a direct target address, a pointer into a vector table built from the I register and the acknowledge byte, or a notice that the acknowledge byte is an instruction the core must execute. The non-maskable path saves the live enable into the saved flag, and the return-from-NMI strobe restores it. The mode in force after the finishing instruction decides the vector form.

Top module: `intctl_top`

## Requirements
- R1: The enable strobe sets both the live and the saved flag. No maskable request is taken at the boundary that ends the enable instruction. A request still present is taken at the following boundary.
- R2: The disable strobe clears both flags. A maskable request at that boundary, or at any later boundary, is not taken.
- R3: The mode strobe reads `im_sel`. The value 00 selects bus mode, 10 selects fixed-restart mode, 11 selects table mode, and 01 leaves the mode unchanged.
- R4: In bus mode, a taken maskable request reports `vec_kind_o` = 2'b10 (execute bus byte), with `vec_addr_o` holding the acknowledge byte zero-extended.
- R5: In fixed-restart mode, a taken maskable request reports `vec_kind_o` = 2'b00 (direct) and `vec_addr_o` = 0x000038.
- R6: In table mode, a taken maskable request reports `vec_kind_o` = 2'b01 (table pointer). `vec_addr_o` is {8'h00, I register, acknowledge byte}.
- R7: A maskable request is taken only when the live flag is 1 after the finishing instruction. `take_o` pulses for one cycle after the boundary, and taking the request clears both flags.
- R8: A rising edge on `nmi_req` is latched and taken at the next boundary whatever the flags hold, ahead of any maskable request. The report is `take_nmi_o` = 1, direct kind and address 0x000066. The live flag clears and the saved flag takes the prior live value.
- R9: The return-from-NMI strobe copies the saved flag into the live flag. The return-from-interrupt strobe leaves both flags unchanged.
- R10: A halt or sleep strobe sets `halted_o`. While suspended, every cycle is a boundary. A taken request clears `halted_o` in the same cycle that `take_o` rises. A maskable request with the live flag at 0 leaves the block suspended.
- R11: Reset clears both flags, `halted_o` and `take_o`, and restores bus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_end | input | 1 | Instruction completes this cycle; qualifies all strobes |
| op_ei | input | 1 | Enable-interrupts instruction |
| op_di | input | 1 | Disable-interrupts instruction |
| op_im | input | 1 | Mode-select instruction |
| im_sel | input | 2 | Mode field of the mode-select instruction |
| op_halt | input | 1 | Halt instruction |
| op_slp | input | 1 | Sleep instruction |
| op_retn | input | 1 | Return from non-maskable service |
| op_reti | input | 1 | Return from maskable service |
| irq_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| i_reg | input | 8 | I register, vector table high byte |
| ack_byte | input | 8 | Byte read from the bus during acknowledge |
| take_o | output | 1 | One-cycle pulse: a request was taken |
| take_nmi_o | output | 1 | The taken request was non-maskable |
| vec_kind_o | output | 2 | 00 direct, 01 table pointer, 10 execute bus byte |
| vec_addr_o | output | 24 | Target, table pointer or bus instruction byte |
| en_live_o | output | 1 | Live enable flag |
| en_saved_o | output | 1 | Saved enable flag |
| halted_o | output | 1 | Core suspended |

## Verification
The request path is tried in each acknowledge mode, with distinct I register and acknowledge byte values, so each vector form can be told apart from the others. Requests that arrive together with enable, disable and the unchanged-mode code separate the enable delay and the after-instruction mode from a design that samples the registered state. A non-maskable edge raised together with a maskable request, with the flags both set and cleared, shows priority and saving, and a later return-from-NMI reveals what was saved. Suspension is entered by both halt and sleep and left by both request types, which shows that only a taken request wakes the core.

// File: rtl/intctl_pkg.sv
// Shared types for the interrupt controller.
// Assumes: the mode and vector-kind codes below are decoded by the core.
package intctl_pkg;
    typedef enum logic [1:0] {
        IMODE_BUS   = 2'd0,
        IMODE_FIXED = 2'd1,
        IMODE_TABLE = 2'd2
    } imode_t;

    typedef enum logic [1:0] {
        VK_DIRECT = 2'b00,
        VK_TABLE  = 2'b01,
        VK_EXEC   = 2'b10
    } vkind_t;
endpackage

// File: rtl/intctl_flags.sv
// Enable flags and acknowledge mode register.
// Applies the finishing instruction's effect first, then any acceptance.
// Assumes: strobes are one-hot and valid only when insn_end is high.
module intctl_flags
    import intctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_end,
    input  logic       op_ei,
    input  logic       op_di,
    input  logic       op_im,
    input  logic [1:0] im_sel,
    input  logic       op_retn,
    input  logic       op_reti,
    input  logic       acc_nmi,
    input  logic       acc_mi,
    output logic       live_q,
    output logic       saved_q,
    output logic       live_after,
    output imode_t     mode_now
);
    logic   saved_after;
    logic   live_d, saved_d;
    imode_t mode_q;

    // Flag values once the finishing instruction has taken effect.
    always_comb begin
        live_after  = live_q;
        saved_after = saved_q;
        if (insn_end) begin
            if (op_retn) live_after = saved_q;
            if (op_di) begin
                live_after  = 1'b0;
                saved_after = 1'b0;
            end
            if (op_ei) begin
                live_after  = 1'b1;
                saved_after = 1'b1;
            end
        end
    end

    // Acceptance overrides: NMI saves the live flag, maskable clears both.
    always_comb begin
        live_d  = live_after;
        saved_d = saved_after;
        if (acc_nmi) begin
            live_d  = 1'b0;
            saved_d = live_after;
        end else if (acc_mi) begin
            live_d  = 1'b0;
            saved_d = 1'b0;
        end
    end

    // Mode in force after the finishing instruction; code 01 keeps it.
    always_comb begin
        mode_now = mode_q;
        if (insn_end && op_im) begin
            case (im_sel)
                2'b00:   mode_now = IMODE_BUS;
                2'b10:   mode_now = IMODE_FIXED;
                2'b11:   mode_now = IMODE_TABLE;
                default: mode_now = mode_q;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            saved_q <= 1'b0;
            mode_q  <= IMODE_BUS;
        end else begin
            live_q  <= live_d;
            saved_q <= saved_d;
            mode_q  <= mode_now;
        end
    end

    assert_ei_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && op_ei && !acc_nmi) |=> (live_q && saved_q));

    assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && op_di) |=> (!live_q && !saved_q));

    assert_retn_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && op_retn && !acc_nmi && !acc_mi) |=> (live_q == $past(saved_q)));

    assert_reti_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && op_reti && !op_ei && !op_di && !op_retn && !acc_nmi && !acc_mi)
        |=> (live_q == $past(live_q) && saved_q == $past(saved_q)));
endmodule

// File: rtl/intctl_arbiter.sv
// Request arbitration and suspended state.
// Latches NMI edges, picks NMI over maskable at a boundary, tracks halt.
// Assumes: while halted the core sends no insn_end.
module intctl_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic op_ei,
    input  logic op_halt,
    input  logic op_slp,
    input  logic irq_req,
    input  logic nmi_req,
    input  logic live_after,
    output logic acc_nmi,
    output logic acc_mi,
    output logic halted_q
);
    logic nmi_q, nmi_pend, boundary;

    // A boundary is an instruction end or any suspended cycle.
    assign boundary = insn_end | halted_q;

    // NMI first; maskable needs the live flag and no enable delay.
    assign acc_nmi = boundary & nmi_pend;
    assign acc_mi  = boundary & irq_req & live_after & ~nmi_pend & ~(insn_end & op_ei);

    // Edge detector, pending latch and halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            halted_q <= 1'b0;
        end else begin
            nmi_q    <= nmi_req;
            nmi_pend <= (nmi_pend & ~acc_nmi) | (nmi_req & ~nmi_q);
            halted_q <= (halted_q | (insn_end & (op_halt | op_slp))) & ~(acc_nmi | acc_mi);
        end
    end

    assert_single_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_nmi && acc_mi));

    assert_nmi_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && boundary) |=> !nmi_pend || $past(nmi_req && !nmi_q));
endmodule

// File: rtl/intctl_vector.sv
// Registers the acceptance pulse and forms the vector for the core.
// Assumes: ack_byte is valid in the boundary cycle of an acceptance.
module intctl_vector
    import intctl_pkg::*;
#(
    parameter int                 ADDR_W    = 24,
    parameter int                 BYTE_W    = 8,
    parameter logic [ADDR_W-1:0]  FIXED_VEC = 'h38,
    parameter logic [ADDR_W-1:0]  NMI_VEC   = 'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_nmi,
    input  logic              acc_mi,
    input  imode_t            mode_now,
    input  logic [BYTE_W-1:0] i_reg,
    input  logic [BYTE_W-1:0] ack_byte,
    output logic              take_q,
    output logic              nmi_q,
    output vkind_t            kind_q,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int PTR_W = 2 * BYTE_W;

    vkind_t            kind_d;
    logic [ADDR_W-1:0] addr_d;

    // Vector form for the current acceptance.
    always_comb begin
        kind_d = VK_DIRECT;
        addr_d = NMI_VEC;
        if (!acc_nmi) begin
            case (mode_now)
                IMODE_FIXED: begin
                    kind_d = VK_DIRECT;
                    addr_d = FIXED_VEC;
                end
                IMODE_TABLE: begin
                    kind_d = VK_TABLE;
                    addr_d = ADDR_W'(PTR_W'({i_reg, ack_byte}));
                end
                default: begin
                    kind_d = VK_EXEC;
                    addr_d = ADDR_W'(ack_byte);
                end
            endcase
        end
    end

    // Output registers, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            nmi_q  <= 1'b0;
            kind_q <= VK_DIRECT;
            addr_q <= '0;
        end else begin
            take_q <= acc_nmi | acc_mi;
            if (acc_nmi | acc_mi) begin
                nmi_q  <= acc_nmi;
                kind_q <= kind_d;
                addr_q <= addr_d;
            end
        end
    end

    assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q || $past(acc_nmi | acc_mi));

    assert_table_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && kind_q == VK_TABLE) |-> (addr_q[ADDR_W-1:PTR_W] == '0));
endmodule

// File: rtl/intctl_top.sv
// Interrupt enable and mode controller top.
// Joins flag state, arbitration and vector forming; outputs are registered.
// Assumes: decoder strobes are one-hot and qualified by insn_end.
module intctl_top
    import intctl_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                BYTE_W    = 8,
    parameter logic [ADDR_W-1:0] FIXED_VEC = 'h38,
    parameter logic [ADDR_W-1:0] NMI_VEC   = 'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_end,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic              op_im,
    input  logic [1:0]        im_sel,
    input  logic              op_halt,
    input  logic              op_slp,
    input  logic              op_retn,
    input  logic              op_reti,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic [BYTE_W-1:0] i_reg,
    input  logic [BYTE_W-1:0] ack_byte,
    output logic              take_o,
    output logic              take_nmi_o,
    output logic [1:0]        vec_kind_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              en_live_o,
    output logic              en_saved_o,
    output logic              halted_o
);
    logic   live_after, acc_nmi, acc_mi;
    imode_t mode_now;
    vkind_t kind_q;

    intctl_flags u_flags (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end),
        .op_ei(op_ei), .op_di(op_di), .op_im(op_im), .im_sel(im_sel),
        .op_retn(op_retn), .op_reti(op_reti),
        .acc_nmi(acc_nmi), .acc_mi(acc_mi),
        .live_q(en_live_o), .saved_q(en_saved_o),
        .live_after(live_after), .mode_now(mode_now)
    );

    intctl_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .op_ei(op_ei),
        .op_halt(op_halt), .op_slp(op_slp),
        .irq_req(irq_req), .nmi_req(nmi_req), .live_after(live_after),
        .acc_nmi(acc_nmi), .acc_mi(acc_mi), .halted_q(halted_o)
    );

    intctl_vector #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
        .FIXED_VEC(FIXED_VEC), .NMI_VEC(NMI_VEC)
    ) u_vec (
        .clk(clk), .rst_n(rst_n), .acc_nmi(acc_nmi), .acc_mi(acc_mi),
        .mode_now(mode_now), .i_reg(i_reg), .ack_byte(ack_byte),
        .take_q(take_o), .nmi_q(take_nmi_o), .kind_q(kind_q), .addr_q(vec_addr_o)
    );

    assign vec_kind_o = kind_q;

    assert_mask_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> (!en_live_o && !en_saved_o));

    assert_nmi_clears_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi_o && take_o |-> (!en_live_o && vec_addr_o == NMI_VEC));

    assert_wake_on_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(halted_o) && $past(rst_n)) |-> take_o);
endmodule

// File: tb/intctl_top_tb.sv
`timescale 1ns/1ps
module intctl_top_tb;
    localparam int OP_NOP = 0, OP_EI = 1, OP_DI = 2, OP_IM = 3, OP_HALT = 4,
                   OP_SLP = 5, OP_RETN = 6, OP_RETI = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_end = 0, op_ei = 0, op_di = 0, op_im = 0, op_halt = 0, op_slp = 0;
    logic op_retn = 0, op_reti = 0, irq_req = 0, nmi_req = 0;
    logic [1:0]  im_sel = 2'b00;
    logic [7:0]  i_reg = 8'h00, ack_byte = 8'h00;
    logic        take_o, take_nmi_o, en_live_o, en_saved_o, halted_o;
    logic [1:0]  vec_kind_o;
    logic [23:0] vec_addr_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [26:0] exp_q[$];
    string       tag_q[$];

    intctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .op_ei(op_ei), .op_di(op_di),
        .op_im(op_im), .im_sel(im_sel), .op_halt(op_halt), .op_slp(op_slp),
        .op_retn(op_retn), .op_reti(op_reti), .irq_req(irq_req), .nmi_req(nmi_req),
        .i_reg(i_reg), .ack_byte(ack_byte), .take_o(take_o), .take_nmi_o(take_nmi_o),
        .vec_kind_o(vec_kind_o), .vec_addr_o(vec_addr_o), .en_live_o(en_live_o),
        .en_saved_o(en_saved_o), .halted_o(halted_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected acceptance {nmi, kind, addr}.
    task automatic expect_take(input string req, input logic nmi, input logic [1:0] kind,
                               input logic [23:0] addr);
        exp_q.push_back({nmi, kind, addr});
        tag_q.push_back(req);
    endtask

    // One instruction boundary carrying a single strobe.
    task automatic insn(input int op, input logic [1:0] sel = 2'b00);
        @(negedge clk);
        insn_end = 1'b1;
        im_sel   = sel;
        op_ei    = (op == OP_EI);
        op_di    = (op == OP_DI);
        op_im    = (op == OP_IM);
        op_halt  = (op == OP_HALT);
        op_slp   = (op == OP_SLP);
        op_retn  = (op == OP_RETN);
        op_reti  = (op == OP_RETI);
        @(negedge clk);
        {insn_end, op_ei, op_di, op_im, op_halt, op_slp, op_retn, op_reti} = '0;
    endtask

    task automatic flags(input string req, input logic live, input logic saved);
        check({req, " live"}, 32'(en_live_o), 32'(live));
        check({req, " saved"}, 32'(en_saved_o), 32'(saved));
    endtask

    // NMI pulse of one cycle; leaves the bench at the negedge after it drops.
    task automatic nmi_pulse();
        @(negedge clk);
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
    endtask

    // Monitor side: pop and compare on every acceptance pulse.
    always @(negedge clk) begin
        if (rst_n && take_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R7: actual unexpected take %h expected none",
                         {take_nmi_o, vec_kind_o, vec_addr_o});
            end else begin
                logic [26:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'({take_nmi_o, vec_kind_o, vec_addr_o}), 32'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 take", 32'(take_o), 0);
        check("R11 halted", 32'(halted_o), 0);
        flags("R11", 0, 0);
        rst_n = 1'b1;

        // R1 + R4: enable delay, then bus mode executes the ack byte
        ack_byte = 8'hA5;
        irq_req  = 1'b1;
        insn(OP_EI);
        check("R1 no take at enable boundary", 32'(take_o), 0);
        flags("R1", 1, 1);
        expect_take("R4", 1'b0, 2'b10, 24'h0000A5);
        insn(OP_NOP);
        irq_req = 1'b0;
        flags("R7 cleared", 0, 0);

        // R5: fixed restart mode
        insn(OP_IM, 2'b10);
        insn(OP_EI);
        irq_req = 1'b1;
        expect_take("R5", 1'b0, 2'b00, 24'h000038);
        insn(OP_NOP);
        irq_req = 1'b0;

        // R3: code 01 keeps fixed mode, request at that boundary
        insn(OP_EI);
        insn(OP_NOP);
        irq_req = 1'b1;
        expect_take("R3 code 01 keeps mode", 1'b0, 2'b00, 24'h000038);
        insn(OP_IM, 2'b01);
        irq_req = 1'b0;

        // R6: table mode
        insn(OP_IM, 2'b11);
        i_reg    = 8'h9C;
        ack_byte = 8'h42;
        insn(OP_EI);
        irq_req = 1'b1;
        expect_take("R6", 1'b0, 2'b01, 24'h009C42);
        insn(OP_NOP);
        irq_req = 1'b0;

        // R2: disable with a request present, then more boundaries
        insn(OP_EI);
        insn(OP_NOP);
        irq_req = 1'b1;
        insn(OP_DI);
        check("R2 no take at disable", 32'(take_o), 0);
        flags("R2", 0, 0);
        insn(OP_NOP);
        check("R7 no take when disabled", 32'(take_o), 0);
        irq_req = 1'b0;

        // R8: NMI over maskable with flags set; R9 restore
        insn(OP_EI);
        insn(OP_NOP);
        nmi_pulse();
        irq_req = 1'b1;
        expect_take("R8 priority", 1'b1, 2'b00, 24'h000066);
        insn(OP_NOP);
        irq_req = 1'b0;
        flags("R8 save", 0, 1);
        insn(OP_RETN);
        flags("R9 retn", 1, 1);
        insn(OP_RETI);
        flags("R9 reti", 1, 1);

        // R8/R9 with flags clear: restore yields 0
        insn(OP_DI);
        nmi_pulse();
        expect_take("R8 masked state", 1'b1, 2'b00, 24'h000066);
        insn(OP_NOP);
        flags("R8 save zero", 0, 0);
        insn(OP_RETN);
        flags("R9 retn zero", 0, 0);

        // R10: halt, masked request does not wake, NMI does
        insn(OP_HALT);
        check("R10 halted", 32'(halted_o), 1);
        irq_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 masked stays halted", 32'(halted_o), 1);
        check("R10 masked no take", 32'(take_o), 0);
        expect_take("R10 nmi wakes", 1'b1, 2'b00, 24'h000066);
        nmi_pulse();
        @(negedge clk);
        check("R10 woke", 32'(halted_o), 0);
        irq_req = 1'b0;

        // R10: sleep, maskable wakes in table mode
        insn(OP_EI);
        insn(OP_SLP);
        check("R10 sleeping", 32'(halted_o), 1);
        expect_take("R10 irq wakes", 1'b0, 2'b01, 24'h009C42);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        check("R10 woke sleep", 32'(halted_o), 0);

        // R11: reset mid-run restores bus mode and clears flags
        insn(OP_EI);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        flags("R11 mid-run", 0, 0);
        rst_n = 1'b1;
        ack_byte = 8'h3C;
        insn(OP_EI);
        irq_req = 1'b1;
        expect_take("R11 mode back to bus", 1'b0, 2'b10, 24'h00003C);
        insn(OP_NOP);
        irq_req = 1'b0;

        repeat (3) @(negedge clk);
        check("R7 all expected takes seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule